// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Level-Compare Interrupts

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins, 16 by default and 5 in a reduced build. Software controls each pin through a small word-addressed register port: it sets a drive value and a drive enable, hands pins to an alternate function source, enables pull-up or pull-down per pin, and reads back the synchronised pin levels. Every write carries a bit mask and a value, so one pin can be changed without a read-modify-write.

Each pin raises a pending interrupt while its synchronised level differs from its polarity bit and its unmask bit is set. The pending bits are ORed into one registered interrupt output, which a separate core enable bit gates. Software builds edge detection on this level scheme: after it services a pin it copies the pin's current level into the polarity bit. That clears the condition until the pin next toggles.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A write with wr_en high changes only the register bits whose wr_mask bit is 1, and each such bit takes the matching wr_data bit. A mask of zero leaves the register unchanged.
- R2: rd_data returns the register at addr one clock after addr is presented. Bits at and above NPIN read as 0, and so does any unmapped address. The map is: 0 pin level (read-only), 1 drive value, 2 drive enable, 3 alternate select, 4 pull-up enable, 5 pull-down enable, 6 interrupt unmask, 7 interrupt polarity, 8 core enable (bit 0), 9 pending vector (read-only).
- R3: pin_oe equals the drive enable register (1 = pin driven, 0 = input). Where the alternate select bit is 0, pin_out equals the drive value register.
- R4: Where the alternate select bit is 1, pin_out follows alt_in for that pin instead of the drive value.
- R5: pull_up and pull_dn come from two independent registers. Writing one never changes the other, so a pin can be given pull-down cleared and pull-up set.
- R6: pin_in passes through two flops before it reaches the pin level register: a change is visible at address 0 after two clock edges, and readable one edge later.
- R7: The pending vector at address 9 equals (level XOR polarity) AND unmask, bit by bit.
- R8: irq_out is a register that, one edge after any pending bit is set, shows the OR of the pending vector ANDed with the core enable bit. It stays high while a pending condition persists and the core enable is set.
- R9: After reset every register is 0, so pin_oe, pin_out, pull_up, pull_dn and irq_out are 0. Clearing the whole unmask register removes every pin from irq_out.
- R10: Writing a pin's current level into its polarity bit clears that pin's pending bit until the pin level next changes. The change then raises it again.
- R11: With NPIN set to 5, only bits 4:0 are stored. An all-ones write to the drive value reads back as 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 4 | Word address for read and write |
| wr_mask | input | 32 | Per-bit write mask |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Registered read data, one cycle latency |
| pin_in | input | NPIN | Asynchronous pin levels |
| alt_in | input | NPIN | Alternate function drive values |
| pin_out | output | NPIN | Value to drive on each pin |
| pin_oe | output | NPIN | Per-pin drive enable |
| pull_up | output | NPIN | Per-pin pull-up enable |
| pull_dn | output | NPIN | Per-pin pull-down enable |
| irq_out | output | 1 | Combined gated interrupt |

## Verification
A pin toggle can reach the pending logic in the same cycle that software rewrites the polarity bit to re-arm, so the two functions meet in a single cycle. The bench first re-arms a pin by writing its level into the polarity bit and sees irq_out fall one edge later. It then toggles that pin and counts the edges: pending reappears after the two synchroniser flops, and irq_out rises on the third edge. The core enable is also switched while a condition is pending, to show that the gate acts within one edge without losing the pending vector.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_LEVEL = 4'd0,
    A_DRV   = 4'd1,
    A_OE    = 4'd2,
    A_ALT   = 4'd3,
    A_PU    = 4'd4,
    A_PD    = 4'd5,
    A_MSK   = 4'd6,
    A_POL   = 4'd7,
    A_CEN   = 4'd8,
    A_PEND  = 4'd9
  } reg_addr_e;

  localparam int FIRST_RW = 1;
  localparam int LAST_RW  = 7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_mreg.sv
module gpio_mreg #(
  parameter int                              W    = 16,
  parameter logic [gpio_irq_pkg::ADDR_W-1:0] ADDR = '0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [gpio_irq_pkg::ADDR_W-1:0]   addr,
  input  logic [W-1:0]                      wr_mask,
  input  logic [W-1:0]                      wr_data,
  output logic [W-1:0]                      q
);
  logic hit;
  assign hit = wr_en && (addr == ADDR);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (hit) q <= (q & ~wr_mask) | (wr_data & wr_mask);
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] msk,
  input  logic         cen,
  output logic [W-1:0] pend,
  output logic         irq_q
);
  assign pend = (lvl ^ pol) & msk;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= cen & (|pend);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wr_mask,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  rd_data,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [NPIN-1:0]   alt_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pull_up,
  output logic [NPIN-1:0]   pull_dn,
  output logic              irq_out
);
  logic [NPIN-1:0] regs [FIRST_RW:LAST_RW];
  logic [NPIN-1:0] lvl, drv, alt_sel, msk, pol, pend;
  logic            core_en_q;
  logic            unused_hi;

  assign unused_hi = ^{wr_mask[BUS_W-1:NPIN], wr_data[BUS_W-1:NPIN]};

  gpio_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  for (genvar g = FIRST_RW; g <= LAST_RW; g++) begin : g_rw
    gpio_mreg #(.W(NPIN), .ADDR(ADDR_W'(g))) u_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
      .wr_mask(wr_mask[NPIN-1:0]), .wr_data(wr_data[NPIN-1:0]),
      .q(regs[g])
    );
  end

  gpio_mreg #(.W(1), .ADDR(A_CEN)) u_cen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_mask(wr_mask[0]), .wr_data(wr_data[0]), .q(core_en_q)
  );

  assign drv     = regs[A_DRV];
  assign pin_oe  = regs[A_OE];
  assign alt_sel = regs[A_ALT];
  assign pull_up = regs[A_PU];
  assign pull_dn = regs[A_PD];
  assign msk     = regs[A_MSK];
  assign pol     = regs[A_POL];

  for (genvar p = 0; p < NPIN; p++) begin : g_pad
    assign pin_out[p] = alt_sel[p] ? alt_in[p] : drv[p];
  end

  gpio_irq_unit #(.W(NPIN)) u_irq (
    .clk(clk), .rst(rst), .lvl(lvl), .pol(pol), .msk(msk),
    .cen(core_en_q), .pend(pend), .irq_q(irq_out)
  );

  logic [NPIN-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    case (addr)
      A_LEVEL: rd_sel = lvl;
      A_DRV:   rd_sel = drv;
      A_OE:    rd_sel = pin_oe;
      A_ALT:   rd_sel = alt_sel;
      A_PU:    rd_sel = pull_up;
      A_PD:    rd_sel = pull_dn;
      A_MSK:   rd_sel = msk;
      A_POL:   rd_sel = pol;
      A_CEN:   rd_sel = NPIN'(core_en_q);
      A_PEND:  rd_sel = pend;
      default: rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= BUS_W'(rd_sel);
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wr_mask,
  input logic [BUS_W-1:0]  wr_data,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   pull_up,
  input logic [NPIN-1:0]   pull_dn,
  input logic              irq_out,
  input logic              core_en,
  input logic [NPIN-1:0]   pend
);
  p_core_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !core_en |=> !irq_out);

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (core_en && (|pend)) |=> irq_out);

  p_oe_masked_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_OE) |=>
      pin_oe == (($past(pin_oe) & ~$past(wr_mask[NPIN-1:0])) |
                 ($past(wr_data[NPIN-1:0]) & $past(wr_mask[NPIN-1:0]))));

  p_oe_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_OE) |=> $stable(pin_oe));

  p_pu_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_PU) |=> $stable(pull_up));

  p_pd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_PD) |=> $stable(pull_dn));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .wr_mask(wr_mask), .wr_data(wr_data), .pin_oe(pin_oe),
  .pull_up(pull_up), .pull_dn(pull_dn), .irq_out(irq_out),
  .core_en(core_en_q), .pend(pend)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  localparam int N = 16;
  localparam int M = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_mask = '0, wr_data = '0, rd_data;
  logic [N-1:0] pin_in = '0, alt_in = '0, pin_out, pin_oe, pull_up, pull_dn;
  logic        irq_out;

  logic        wr_en1 = 1'b0;
  logic [3:0]  addr1 = '0;
  logic [31:0] rd_data1;
  logic [M-1:0] pin_out1, pin_oe1, pull_up1, pull_dn1;
  logic        irq_out1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NPIN(N)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_mask(wr_mask),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in), .alt_in(alt_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_up(pull_up), .pull_dn(pull_dn),
    .irq_out(irq_out)
  );

  gpio_irq_ctrl #(.NPIN(M)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en1), .addr(addr1), .wr_mask(32'hFFFF_FFFF),
    .wr_data(32'hFFFF_FFFF), .rd_data(rd_data1), .pin_in('0), .alt_in('0),
    .pin_out(pin_out1), .pin_oe(pin_oe1), .pull_up(pull_up1), .pull_dn(pull_dn1),
    .irq_out(irq_out1)
  );

  // mask, data, expected drive value after the write
  localparam logic [47:0] VEC [6] = '{
    {16'hFFFF, 16'hA5A5, 16'hA5A5},
    {16'h00FF, 16'h0000, 16'hA500},
    {16'hF000, 16'hFFFF, 16'hF500},
    {16'h0000, 16'hFFFF, 16'hF500},
    {16'h0F0F, 16'h1234, 16'hF204},
    {16'h8001, 16'h0000, 16'h7204}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] m, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_mask = m; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0; wr_data = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk("R9 pin_oe", 32'(pin_oe), 0);
    chk("R9 pin_out", 32'(pin_out), 0);
    chk("R9 pulls", 32'({pull_up, pull_dn}), 0);
    chk("R9 irq_out", 32'(irq_out), 0);
    rd(4'd6, v); chk("R9 unmask", v, 0);

    // R1 masked write vector table
    for (int i = 0; i < 6; i++) begin
      wr(4'd1, 32'(VEC[i][47:32]), 32'(VEC[i][31:16]));
      chk("R1 pin_out", 32'(pin_out), 32'(VEC[i][15:0]));
      rd(4'd1, v);
      chk("R1 readback", v, 32'(VEC[i][15:0]));
    end

    // R2 unmapped address and zero extension
    rd(4'd15, v); chk("R2 unmapped", v, 0);

    // R3 drive enable
    wr(4'd2, 32'hFFFF, 32'hFFFF_00F0);
    chk("R3 pin_oe", 32'(pin_oe), 32'h00F0);
    rd(4'd2, v); chk("R2 zero-extended", v, 32'h00F0);

    // R4 alternate select
    alt_in = 16'h000A;
    wr(4'd3, 32'h000F, 32'h000F);
    chk("R4 alt pin_out", 32'(pin_out), 32'h720A);

    // R5 pulls: set, then give pin 2 pull-down cleared, pull-up set
    wr(4'd4, 32'hFFFF, 32'h0003);
    wr(4'd5, 32'hFFFF, 32'h0004);
    chk("R5 pull_up", 32'(pull_up), 32'h0003);
    wr(4'd5, 32'h0004, 32'h0000);
    wr(4'd4, 32'h0004, 32'h0004);
    chk("R5 pull_dn", 32'(pull_dn), 32'h0000);
    chk("R5 pull_up req", 32'(pull_up), 32'h0007);

    // R6 synchroniser latency
    pin_in = 16'h1234; addr = 4'd0;
    @(negedge clk); @(negedge clk);
    chk("R6 level early", rd_data, 0);
    @(negedge clk);
    chk("R6 level", rd_data, 32'h1234);

    // R7 pending vector, R8 core gate off
    wr(4'd6, 32'hFFFF, 32'h00FF);
    rd(4'd9, v); chk("R7 pending", v, 32'h0034);
    chk("R8 gated off", 32'(irq_out), 0);
    wr(4'd8, 32'h1, 32'h1);
    @(negedge clk);
    chk("R8 irq_out", 32'(irq_out), 1);

    // R10 re-arm by copying level into polarity
    wr(4'd7, 32'h00FF, 32'h0034);
    @(negedge clk);
    rd(4'd9, v); chk("R10 cleared", v, 0);
    chk("R10 irq low", 32'(irq_out), 0);
    pin_in = 16'h1235;
    @(negedge clk); @(negedge clk);
    chk("R10 irq not yet", 32'(irq_out), 0);
    @(negedge clk);
    chk("R10 irq on toggle", 32'(irq_out), 1);
    rd(4'd9, v); chk("R10 pending bit0", v, 32'h0001);

    // R8 gate removed while pending persists
    wr(4'd8, 32'h1, 32'h0);
    @(negedge clk);
    chk("R8 gate clears", 32'(irq_out), 0);
    rd(4'd9, v); chk("R8 pending kept", v, 32'h0001);

    // R9 clear all unmask bits
    wr(4'd8, 32'h1, 32'h1);
    wr(4'd6, 32'hFFFF, 32'h0);
    @(negedge clk);
    chk("R9 unmask clear irq", 32'(irq_out), 0);
    rd(4'd9, v); chk("R9 unmask clear pend", v, 0);

    // R11 narrow build
    @(negedge clk); wr_en1 = 1'b1; addr1 = 4'd1;
    @(negedge clk); wr_en1 = 1'b0;
    @(negedge clk);
    chk("R11 rd narrow", rd_data1, 32'h1F);
    chk("R11 pin_out narrow", 32'(pin_out1), 32'h1F);

    finish_run();
  end
endmodule